// File: doc/BRIEF.md
# Stereo Reverse-to-Forward Crossfader

This block performs the hand-off from a reversed stereo stream back to the live forward stream without an audible step. A start strobe arms a 16-bit gain at full scale. Each following sample strobe lowers the gain by a fixed step. The block then outputs, per channel, the reverse sample weighted by the gain plus the forward sample weighted by the bitwise complement of the gain. The upper half of that sum is the output. When the down-counter reaches zero or would go below zero, the block emits the forward sample unchanged, pulses done, and returns to idle.

When no ramp is running, the reverse input passes straight through. This lets a sequencer feed the block continuously. Results are registered and valid one cycle after each sample strobe. Sample storage and the control of the reverse playback belong to the surrounding logic.

Top module: `xfade_stereo`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mix_l_o`, `mix_r_o`, `out_vld_o` and `done_o` are zero, and no ramp is active.
- R2: `out_vld_o` is high exactly in the cycle after a cycle with `smp_i` high. The outputs change only on those cycles and hold their values otherwise.
- R3: When idle, a sample outputs the reverse inputs unchanged.
- R4: `start_i` loads the gain with 0xFFFF and starts a ramp. A sample strobe in the same cycle as `start_i` is treated as idle (reverse passthrough).
- R5: During a ramp, each sample first lowers the gain by STEP (default 0x0080). With g the new gain, each channel then outputs floor((rev*g + fwd*(0xFFFF-g)) / 65536). Samples are signed 16-bit and g is unsigned.
- R6: If the decrement gives exactly zero or borrows, that sample outputs the forward inputs unchanged, `done_o` is high with that `out_vld_o`, and the ramp ends. With STEP 0x0080 this happens on the 512th sample after start, after 511 blended samples.
- R7: Both channels use the same gain value on every sample.
- R8: `done_o` is high only together with `out_vld_o`, and for one cycle per ramp.
- R9: `start_i` during a running ramp restarts it from 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arms a new ramp at full reverse gain |
| smp_i | input | 1 | One-cycle strobe per stereo sample |
| rev_l_i | input | 16 | Reverse left sample, signed |
| rev_r_i | input | 16 | Reverse right sample, signed |
| fwd_l_i | input | 16 | Forward left sample, signed |
| fwd_r_i | input | 16 | Forward right sample, signed |
| mix_l_o | output | 16 | Left output, signed, registered |
| mix_r_o | output | 16 | Right output, signed, registered |
| out_vld_o | output | 1 | Output valid, one cycle after `smp_i` |
| done_o | output | 1 | Pulse on the final sample of a ramp |

## Verification
The bench counts samples across a full ramp, with idle gaps between strobes. A counter that ends one sample early or late, or ends only on an exact zero, puts `done_o` and the forward passthrough on the wrong sample. Full-scale operand pairs of opposite sign test the product width and the floor truncation. A mixer that used the gain before the decrement, or rounded, is off by one step or one LSB. Start coinciding with a sample, and restart in mid-ramp, expose a ramp that is not reloaded or a coincident sample wrongly blended.

// File: rtl/xfade_pkg.sv
package xfade_pkg;
  typedef enum logic [1:0] {
    SEL_REV = 2'd0,
    SEL_MIX = 2'd1,
    SEL_FWD = 2'd2
  } xf_sel_e;
endpackage

// File: rtl/xf_gain_ramp.sv
module xf_gain_ramp
  import xfade_pkg::*;
#(
  parameter int GW   = 16,
  parameter int STEP = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          smp_i,
  output logic [GW-1:0] gain_o,
  output xf_sel_e       sel_o,
  output logic          last_o
);
  localparam logic [GW-1:0] GFULL = {GW{1'b1}};
  localparam logic [GW:0]   STEPX = (GW+1)'(STEP);

  logic [GW-1:0] gain_q;
  logic          run_q;
  logic [GW:0]   diff;
  logic          term;

  assign diff = {1'b0, gain_q} - STEPX;
  assign term = diff[GW] || (diff[GW-1:0] == '0);

  always_comb begin
    if (start_i || !run_q) sel_o = SEL_REV;
    else if (term)         sel_o = SEL_FWD;
    else                   sel_o = SEL_MIX;
  end

  assign gain_o = diff[GW-1:0];
  assign last_o = smp_i && !start_i && run_q && term;

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= '0;
      run_q  <= 1'b0;
    end else if (start_i) begin
      gain_q <= GFULL;
      run_q  <= 1'b1;
    end else if (smp_i && run_q) begin
      if (term) begin
        gain_q <= '0;
        run_q  <= 1'b0;
      end else begin
        gain_q <= diff[GW-1:0];
      end
    end
  end

  // R4 / R9: a start always arms the full-scale gain
  a_r4_start_loads: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (run_q && gain_q == GFULL));
  // R6: the final sample ends the ramp
  a_r6_last_stops: assert property (@(posedge clk) disable iff (rst)
    last_o |=> !run_q);
  // R5: while running, the gain never rises without a start
  a_r5_monotone: assert property (@(posedge clk) disable iff (rst)
    (run_q && !start_i) |=> (gain_q <= $past(gain_q)));
endmodule

// File: rtl/xf_chan_mix.sv
module xf_chan_mix
  import xfade_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  xf_sel_e              sel_i,
  input  logic        [GW-1:0] gain_i,
  input  logic signed [DW-1:0] rev_i,
  input  logic signed [DW-1:0] fwd_i,
  output logic signed [DW-1:0] mix_o
);
  localparam int PW = DW + GW + 1;
  localparam int AW = PW + 1;

  logic signed [GW:0]   g_rev, g_fwd;
  logic signed [PW-1:0] p_rev, p_fwd;
  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] nxt;

  assign g_rev = $signed({1'b0, gain_i});
  assign g_fwd = $signed({1'b0, ~gain_i});
  assign p_rev = PW'(rev_i) * PW'(g_rev);
  assign p_fwd = PW'(fwd_i) * PW'(g_fwd);
  assign acc   = AW'(p_rev) + AW'(p_fwd);

  always_comb begin
    unique case (sel_i)
      SEL_MIX: nxt = acc[DW+GW-1:GW];
      SEL_FWD: nxt = fwd_i;
      default: nxt = rev_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       mix_o <= '0;
    else if (en_i) mix_o <= nxt;
  end

  // R2: the output holds between sample strobes
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(mix_o));
endmodule

// File: rtl/xfade_stereo.sv
module xfade_stereo
  import xfade_pkg::*;
#(
  parameter int DW   = 16,
  parameter int GW   = 16,
  parameter int STEP = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 smp_i,
  input  logic signed [DW-1:0] rev_l_i,
  input  logic signed [DW-1:0] rev_r_i,
  input  logic signed [DW-1:0] fwd_l_i,
  input  logic signed [DW-1:0] fwd_r_i,
  output logic signed [DW-1:0] mix_l_o,
  output logic signed [DW-1:0] mix_r_o,
  output logic                 out_vld_o,
  output logic                 done_o
);
  localparam int NCH = 2;

  logic [GW-1:0] gain;
  xf_sel_e       sel;
  logic          last;
  logic signed [DW-1:0] rev_a [NCH];
  logic signed [DW-1:0] fwd_a [NCH];
  logic signed [DW-1:0] mix_a [NCH];

  assign rev_a[0] = rev_l_i;
  assign rev_a[1] = rev_r_i;
  assign fwd_a[0] = fwd_l_i;
  assign fwd_a[1] = fwd_r_i;

  xf_gain_ramp #(.GW(GW), .STEP(STEP)) ramp_i (
    .clk(clk), .rst(rst), .start_i(start_i), .smp_i(smp_i),
    .gain_o(gain), .sel_o(sel), .last_o(last)
  );

  // R7: one shared gain feeds every channel
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    xf_chan_mix #(.DW(DW), .GW(GW)) mix_i (
      .clk(clk), .rst(rst), .en_i(smp_i), .sel_i(sel), .gain_i(gain),
      .rev_i(rev_a[c]), .fwd_i(fwd_a[c]), .mix_o(mix_a[c])
    );
  end

  assign mix_l_o = mix_a[0];
  assign mix_r_o = mix_a[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      out_vld_o <= smp_i;
      done_o    <= last;
    end
  end

  // R2: valid follows the strobe by exactly one cycle
  a_r2_vld_after_smp: assert property (@(posedge clk) disable iff (rst)
    smp_i |=> out_vld_o);
  a_r2_no_vld_without_smp: assert property (@(posedge clk) disable iff (rst)
    !smp_i |=> !out_vld_o);
  // R8: done rides on a valid output and lasts one cycle
  a_r8_done_with_vld: assert property (@(posedge clk) disable iff (rst)
    done_o |-> out_vld_o);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: tb/xfade_stereo_tb_top.sv
module xfade_stereo_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, smp_i = 1'b0;
  logic signed [15:0] rev_l_i = '0, rev_r_i = '0, fwd_l_i = '0, fwd_r_i = '0;
  logic signed [15:0] mix_l_o, mix_r_o;
  logic out_vld_o, done_o;

  int n_chk = 0, n_bad = 0;
  bit m_run = 0;
  int m_g   = 0;
  int seed  = 32'h5eed_0042;

  always #5 clk = ~clk;

  xfade_stereo dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .smp_i(smp_i),
    .rev_l_i(rev_l_i), .rev_r_i(rev_r_i), .fwd_l_i(fwd_l_i), .fwd_r_i(fwd_r_i),
    .mix_l_o(mix_l_o), .mix_r_o(mix_r_o), .out_vld_o(out_vld_o), .done_o(done_o)
  );

  function automatic logic signed [15:0] blend(int rv, int fw, int g);
    longint s;
    s = longint'(rv) * g + longint'(fw) * (65535 - g);
    return 16'(s >>> 16);
  endfunction

  task automatic chk(string rq, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // drive one sample with given inputs; check registered result
  task automatic sample(bit st, int rl, int rr, int fl, int fr, string rq);
    logic signed [15:0] el, er;
    bit ed;
    int d;
    ed = 0;
    if (st || !m_run) begin
      el = 16'(rl); er = 16'(rr);
    end else begin
      d = m_g - 128;
      if (d <= 0) begin
        el = 16'(fl); er = 16'(fr); ed = 1; m_run = 0;
      end else begin
        m_g = d;
        el = blend(rl, fl, d); er = blend(rr, fr, d);
      end
    end
    if (st) begin m_run = 1; m_g = 65535; end
    @(negedge clk);
    start_i = st; smp_i = 1'b1;
    rev_l_i = 16'(rl); rev_r_i = 16'(rr); fwd_l_i = 16'(fl); fwd_r_i = 16'(fr);
    @(negedge clk);
    start_i = 1'b0; smp_i = 1'b0;
    chk({rq, " R2 vld"}, out_vld_o, 1);
    chk({rq, " left"}, mix_l_o, el);
    chk({rq, " R7 right"}, mix_r_o, er);
    chk({rq, " R8 done"}, done_o, ed);
  endtask

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  task automatic rsample(bit st, string rq);
    sample(st, rnd16(), rnd16(), rnd16(), rnd16(), rq);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic signed [15:0] hl;
    int cnt;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 reset vld", out_vld_o, 0);
    chk("R1 reset done", done_o, 0);
    chk("R1 reset left", mix_l_o, 0);
    @(negedge clk); rst = 1'b0;
    chk("R1 post-reset right", mix_r_o, 0);

    for (int i = 0; i < 8; i++) rsample(0, "R3 idle pass");
    // R2: no strobe -> no valid, outputs hold
    hl = mix_l_o;
    @(negedge clk);
    chk("R2 idle vld", out_vld_o, 0);
    chk("R2 hold", mix_l_o, hl);

    // R4 start with coincident sample passes reverse; R5/R6 full ramp
    rsample(1, "R4 start+smp");
    sample(0, 32767, -32768, -32768, 32767, "R5 first blend g=FF7F");
    cnt = 1;
    while (m_run) begin
      if (($urandom % 4) == 0) @(negedge clk);
      rsample(0, "R5 ramp");
      cnt++;
    end
    chk("R6 samples to end", cnt, 512);
    for (int i = 0; i < 4; i++) rsample(0, "R3 idle after");

    // R9 restart mid-ramp
    sample(1, 100, 100, 100, 100, "R9 start");
    for (int i = 0; i < 50; i++) rsample(0, "R9 ramp a");
    rsample(1, "R9 restart");
    sample(0, -32768, -32768, -32768, -32768, "R5 floor neg");
    sample(0, 100, -100, 100, -100, "R5 floor equal");
    cnt = 2;
    while (m_run) begin rsample(0, "R9 ramp b"); cnt++; end
    chk("R9 restart length", cnt, 512);
    rsample(0, "R3 idle final");
    finish_run();
  end
endmodule